// File: doc/BRIEF.md
# Timer Service Request Unit

This unit sits next to an event-driven counter/timer and converts its single-cycle event strobes into service requests. Every event strobe sets a sticky flag; software clears flags by writing ones to them. A per-event enable mask selects which flags may raise the single interrupt line. Each of two DMA request channels watches a programmable subset of the events, and can also fire when the timer copies its reload values into its match registers. Once fired, a DMA request stays pending until the DMA channel acknowledges it with a one-cycle pulse.

Software reaches the unit through a small word-addressed register bus. Each write takes one strobe cycle and read data follows the address combinationally. Word 0 and word 1 configure DMA channels 0 and 1, word 2 holds the interrupt enables and word 3 holds the event flags. Reset is synchronous and active low.

Top module: `tmr_svc_req`

## Requirements
- R1: After reset, every register word reads zero and `irq_o` and `dma_req_o` are low.
- R2: A one on `evt_i[n]` sets event flag bit n (word 3, bit n) at the next clock edge.
- R3: Writing word 3 clears each flag bit whose data bit is one. Flag bits written with zero keep their value, and no flag clears without such a write.
- R4: When an event strobe and a clearing write hit the same flag bit in one cycle, the flag stays set.
- R5: `irq_o` is high exactly when some bit is one in both the enable word (word 2, bit n for event n) and the flag word. It follows register changes one cycle after the strobe or write that causes them.
- R6: A DMA channel becomes pending one cycle after any event whose bit is set in that channel's mask (bits 15:0 of word 0 or word 1). Events outside the mask leave the channel idle.
- R7: When bit 30 of a channel's word is one, a `reload_i` strobe makes that channel pending one cycle later. When bit 30 is zero, a reload strobe has no effect on that channel.
- R8: A pulse on `dma_ack_i[k]` clears pending request k. If a trigger for channel k arrives in the same cycle as the acknowledge, the request stays pending. Without an acknowledge, a pending request stays pending.
- R9: Bit 31 of a channel's word reads the pending state, which is also driven on `dma_req_o[k]`. Writes to bit 31 have no effect.
- R10: Reserved bits read zero and ignore writes. These are bits 29:16 of words 0 and 1 and bits 31:16 of words 2 and 3.
- R11: Reads decode the word address: 0 and 1 are the DMA channel words, 2 is the interrupt enable word and 3 is the flag word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 16 | Per-event single-cycle strobes, event n on bit n |
| reload_i | input | 1 | Strobe marking a reload-to-match copy |
| dma_ack_i | input | 2 | Per-channel DMA acknowledge pulses |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address for read and write |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 2 | DMA request lines, channel k on bit k |

## Verification
The properties assume that events, reload and acknowledge arrive as clean single-cycle pulses. They also assume that the enable word only changes through the register bus. As a result, the interrupt line and the pending requests may change only in the cycle after a strobe, acknowledge or write. The stimulus drives every input for exactly one full clock period, from one falling edge to the next, and returns strobes to zero in between. It never issues a write and a read of a different word in the same cycle, so the combinational read port always shows the settled register state.

// File: rtl/tmr_svc_pkg.sv
package tmr_svc_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned RLD_POS  = 30;
   localparam int unsigned STAT_POS = 31;

   function automatic int unsigned en_word(input int unsigned ndma);
      return ndma;
   endfunction

   function automatic int unsigned flag_word(input int unsigned ndma);
      return ndma + 1;
   endfunction
endpackage

// File: rtl/tmr_svc_flags.sv
module tmr_svc_flags #(
   parameter int unsigned NUM_EVENTS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVENTS-1:0] evt_i,
   input  logic                  en_wr_i,
   input  logic                  flag_wr_i,
   input  logic [NUM_EVENTS-1:0] wbits_i,
   output logic [NUM_EVENTS-1:0] en_o,
   output logic [NUM_EVENTS-1:0] flag_o,
   output logic                  irq_o
);
   logic [NUM_EVENTS-1:0] en_q, flag_q, clr_mask, flag_d;

   // A clearing write and a same-cycle strobe: the strobe wins.
   assign clr_mask = flag_wr_i ? wbits_i : '0;
   assign flag_d   = (flag_q & ~clr_mask) | evt_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         flag_q <= '0;
      end else begin
         flag_q <= flag_d;
         if (en_wr_i) en_q <= wbits_i;
      end
   end

   assign en_o   = en_q;
   assign flag_o = flag_q;
   assign irq_o  = |(en_q & flag_q);
endmodule

// File: rtl/tmr_svc_dma_chan.sv
module tmr_svc_dma_chan #(
   parameter int unsigned NUM_EVENTS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVENTS-1:0] evt_i,
   input  logic                  reload_i,
   input  logic                  ack_i,
   input  logic                  cfg_wr_i,
   input  logic [NUM_EVENTS-1:0] mask_wdata_i,
   input  logic                  rld_wdata_i,
   output logic [NUM_EVENTS-1:0] mask_o,
   output logic                  rld_en_o,
   output logic                  pend_o
);
   logic [NUM_EVENTS-1:0] mask_q;
   logic                  rld_q, pend_q, trig;

   assign trig = (|(evt_i & mask_q)) | (reload_i & rld_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         rld_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (cfg_wr_i) begin
            mask_q <= mask_wdata_i;
            rld_q  <= rld_wdata_i;
         end
         if (trig)       pend_q <= 1'b1;
         else if (ack_i) pend_q <= 1'b0;
      end
   end

   assign mask_o   = mask_q;
   assign rld_en_o = rld_q;
   assign pend_o   = pend_q;
endmodule

// File: rtl/tmr_svc_regif.sv
module tmr_svc_regif
   import tmr_svc_pkg::*;
#(
   parameter int unsigned NUM_EVENTS = 16,
   parameter int unsigned NUM_DMA    = 2,
   parameter int unsigned ADDR_W     = 2
) (
   input  logic                               wr_en_i,
   input  logic [ADDR_W-1:0]                  addr_i,
   input  logic [REG_W-1:0]                   wdata_i,
   input  logic [NUM_DMA-1:0][NUM_EVENTS-1:0] dma_mask_i,
   input  logic [NUM_DMA-1:0]                 dma_rld_i,
   input  logic [NUM_DMA-1:0]                 dma_pend_i,
   input  logic [NUM_EVENTS-1:0]              en_i,
   input  logic [NUM_EVENTS-1:0]              flag_i,
   output logic [NUM_DMA-1:0]                 dma_wr_o,
   output logic                               en_wr_o,
   output logic                               flag_wr_o,
   output logic [NUM_EVENTS-1:0]              evbits_o,
   output logic                               rld_bit_o,
   output logic [REG_W-1:0]                   rdata_o
);
   localparam int unsigned NWORDS = NUM_DMA + 2;

   logic [REG_W-1:0] words [NWORDS];
   logic             unused_wbits;

   assign evbits_o     = wdata_i[NUM_EVENTS-1:0];
   assign rld_bit_o    = wdata_i[RLD_POS];
   assign unused_wbits = ^{wdata_i[STAT_POS], wdata_i[RLD_POS-1:NUM_EVENTS]};

   assign en_wr_o   = wr_en_i && (32'(addr_i) == en_word(NUM_DMA));
   assign flag_wr_o = wr_en_i && (32'(addr_i) == flag_word(NUM_DMA));

   for (genvar k = 0; k < NUM_DMA; k++) begin : g_chan_word
      assign dma_wr_o[k] = wr_en_i && (32'(addr_i) == k);
      always_comb begin
         words[k]                 = '0;
         words[k][NUM_EVENTS-1:0] = dma_mask_i[k];
         words[k][RLD_POS]        = dma_rld_i[k];
         words[k][STAT_POS]       = dma_pend_i[k];
      end
   end

   always_comb begin
      words[NUM_DMA]                       = '0;
      words[NUM_DMA][NUM_EVENTS-1:0]       = en_i;
      words[NUM_DMA + 1]                   = '0;
      words[NUM_DMA + 1][NUM_EVENTS-1:0]   = flag_i;
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NWORDS; i++) begin
         if (32'(addr_i) == i) rdata_o = words[i];
      end
   end
endmodule

// File: rtl/tmr_svc_req.sv
module tmr_svc_req
   import tmr_svc_pkg::*;
#(
   parameter int unsigned NUM_EVENTS = 16,
   parameter int unsigned NUM_DMA    = 2,
   parameter int unsigned ADDR_W     = $clog2(NUM_DMA + 2)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVENTS-1:0] evt_i,
   input  logic                  reload_i,
   input  logic [NUM_DMA-1:0]    dma_ack_i,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [REG_W-1:0]      wdata_i,
   output logic [REG_W-1:0]      rdata_o,
   output logic                  irq_o,
   output logic [NUM_DMA-1:0]    dma_req_o
);
   if (NUM_EVENTS < 1 || NUM_EVENTS >= RLD_POS) begin : g_bad_events
      initial $fatal(1, "NUM_EVENTS must lie in 1..29");
   end
   if (NUM_DMA < 1) begin : g_bad_dma
      initial $fatal(1, "NUM_DMA must be at least 1");
   end
   if ((1 << ADDR_W) < NUM_DMA + 2) begin : g_bad_addr
      initial $fatal(1, "ADDR_W too narrow for the register words");
   end

   logic [NUM_DMA-1:0][NUM_EVENTS-1:0] dma_mask;
   logic [NUM_DMA-1:0]                 dma_rld, dma_pend, dma_wr;
   logic [NUM_EVENTS-1:0]              en_q, flag_q, evbits;
   logic                               en_wr, flag_wr, rld_bit;

   tmr_svc_regif #(
      .NUM_EVENTS(NUM_EVENTS), .NUM_DMA(NUM_DMA), .ADDR_W(ADDR_W)
   ) u_regif (
      .wr_en_i   (wr_en_i),
      .addr_i    (addr_i),
      .wdata_i   (wdata_i),
      .dma_mask_i(dma_mask),
      .dma_rld_i (dma_rld),
      .dma_pend_i(dma_pend),
      .en_i      (en_q),
      .flag_i    (flag_q),
      .dma_wr_o  (dma_wr),
      .en_wr_o   (en_wr),
      .flag_wr_o (flag_wr),
      .evbits_o  (evbits),
      .rld_bit_o (rld_bit),
      .rdata_o   (rdata_o)
   );

   tmr_svc_flags #(.NUM_EVENTS(NUM_EVENTS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i),
      .en_wr_i  (en_wr),
      .flag_wr_i(flag_wr),
      .wbits_i  (evbits),
      .en_o     (en_q),
      .flag_o   (flag_q),
      .irq_o    (irq_o)
   );

   for (genvar k = 0; k < NUM_DMA; k++) begin : g_dma
      tmr_svc_dma_chan #(.NUM_EVENTS(NUM_EVENTS)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .evt_i       (evt_i),
         .reload_i    (reload_i),
         .ack_i       (dma_ack_i[k]),
         .cfg_wr_i    (dma_wr[k]),
         .mask_wdata_i(evbits),
         .rld_wdata_i (rld_bit),
         .mask_o      (dma_mask[k]),
         .rld_en_o    (dma_rld[k]),
         .pend_o      (dma_pend[k])
      );
   end

   assign dma_req_o = dma_pend;
endmodule

// File: rtl/tmr_svc_req_chk.sv
module tmr_svc_req_chk
   import tmr_svc_pkg::*;
#(
   parameter int unsigned NUM_EVENTS = 16,
   parameter int unsigned NUM_DMA    = 2,
   parameter int unsigned ADDR_W     = 2
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [NUM_EVENTS-1:0]              evt_i,
   input logic                               reload_i,
   input logic [NUM_DMA-1:0]                 dma_ack_i,
   input logic                               wr_en_i,
   input logic [ADDR_W-1:0]                  addr_i,
   input logic [REG_W-1:0]                   rdata_o,
   input logic                               irq_o,
   input logic [NUM_DMA-1:0]                 dma_req_o,
   input logic [NUM_EVENTS-1:0]              flag_q,
   input logic [NUM_EVENTS-1:0]              en_q,
   input logic [NUM_DMA-1:0][NUM_EVENTS-1:0] dma_mask,
   input logic [NUM_DMA-1:0]                 dma_rld
);
   logic flag_write, any_write;
   assign flag_write = wr_en_i && (32'(addr_i) == flag_word(NUM_DMA));
   assign any_write  = wr_en_i;

   assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

   assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_write |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   assert_irq_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & en_q) != '0 && !any_write) |=> irq_o);

   assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !any_write) |=> irq_o);

   assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_o[RLD_POS-1:NUM_EVENTS] == '0);

   for (genvar k = 0; k < NUM_DMA; k++) begin : g_chan
      assert_dma_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ((evt_i & dma_mask[k]) != '0) |=> dma_req_o[k]);

      assert_dma_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (reload_i && dma_rld[k]) |=> dma_req_o[k]);

      assert_dma_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (dma_ack_i[k] && ((evt_i & dma_mask[k]) == '0) && !(reload_i && dma_rld[k]))
         |=> !dma_req_o[k]);

      assert_dma_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (dma_req_o[k] && !dma_ack_i[k]) |=> dma_req_o[k]);

      assert_status_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(addr_i) == k) |-> (rdata_o[STAT_POS] == dma_req_o[k]));
   end
endmodule

bind tmr_svc_req tmr_svc_req_chk #(
   .NUM_EVENTS(NUM_EVENTS), .NUM_DMA(NUM_DMA), .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_i    (evt_i),
   .reload_i (reload_i),
   .dma_ack_i(dma_ack_i),
   .wr_en_i  (wr_en_i),
   .addr_i   (addr_i),
   .rdata_o  (rdata_o),
   .irq_o    (irq_o),
   .dma_req_o(dma_req_o),
   .flag_q   (flag_q),
   .en_q     (en_q),
   .dma_mask (dma_mask),
   .dma_rld  (dma_rld)
);

// File: tb/tmr_svc_req_bench.sv
`timescale 1ns/1ps
module tmr_svc_req_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] evt = '0;
   logic        reload = 1'b0;
   logic [1:0]  ack = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic [1:0]  dreq;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   tmr_svc_req u_tmr_svc_req (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .reload_i(reload),
      .dma_ack_i(ack), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .irq_o(irq), .dma_req_o(dreq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // Drive one full clock period of stimulus, falling edge to falling edge.
   task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d,
                      input logic [15:0] e, input logic r, input logic [1:0] k);
      @(negedge clk);
      wr_en = w; addr = a; wdata = d; evt = e; reload = r; ack = k;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0; evt = '0; reload = 1'b0; ack = '0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, '0, 1'b0, '0);
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #0.5;
      d = rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int i = 0; i < 4; i++) begin
         rd(2'(i), v);
         chk("R1 reset word", v, 32'h0);
      end
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);
      chk("R1 dma after reset", {30'b0, dreq}, 32'h0);
   endtask

   task automatic t_flags();
      logic [31:0] v;
      cyc(1'b0, 2'd0, '0, 16'h8001, 1'b0, '0);
      rd(2'd3, v); chk("R2 flags set by events", v, 32'h0000_8001);
      wr(2'd3, 32'h0000_0001);
      rd(2'd3, v); chk("R3 write one clears bit", v, 32'h0000_8000);
      wr(2'd3, 32'h0000_0000);
      rd(2'd3, v); chk("R3 write zero keeps flags", v, 32'h0000_8000);
      wr(2'd3, 32'h0000_FFFF);
      rd(2'd3, v); chk("R3 clear all flags", v, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      cyc(1'b0, 2'd0, '0, 16'h0008, 1'b0, '0);
      cyc(1'b1, 2'd3, 32'h0000_0028, 16'h0028, 1'b0, '0);
      rd(2'd3, v); chk("R4 event beats clearing write", v, 32'h0000_0028);
      wr(2'd3, 32'h0000_FFFF);
      rd(2'd3, v); chk("R4 flags clear afterwards", v, 32'h0);
   endtask

   task automatic t_irq();
      wr(2'd2, 32'h0000_0010);
      cyc(1'b0, 2'd0, '0, 16'h0004, 1'b0, '0);
      chk("R5 disabled event no irq", {31'b0, irq}, 32'h0);
      cyc(1'b0, 2'd0, '0, 16'h0010, 1'b0, '0);
      chk("R5 enabled event raises irq", {31'b0, irq}, 32'h1);
      wr(2'd3, 32'h0000_0010);
      chk("R5 clearing enabled flag drops irq", {31'b0, irq}, 32'h0);
      wr(2'd2, 32'h0000_0014);
      chk("R5 enabling pending flag raises irq", {31'b0, irq}, 32'h1);
      wr(2'd2, 32'h0000_0000);
      chk("R5 disabling drops irq", {31'b0, irq}, 32'h0);
      wr(2'd3, 32'h0000_FFFF);
   endtask

   task automatic t_dma_evt();
      logic [31:0] v;
      wr(2'd0, 32'h0000_00F0);
      wr(2'd1, 32'h0000_0F00);
      cyc(1'b0, 2'd0, '0, 16'h0002, 1'b0, '0);
      chk("R6 unmasked event no request", {30'b0, dreq}, 32'h0);
      cyc(1'b0, 2'd0, '0, 16'h0020, 1'b0, '0);
      chk("R6 masked event requests ch0 only", {30'b0, dreq}, 32'h1);
      rd(2'd0, v); chk("R9 R11 ch0 word shows pending", v, 32'h8000_00F0);
      rd(2'd1, v); chk("R11 ch1 word", v, 32'h0000_0F00);
      cyc(1'b0, 2'd0, '0, '0, 1'b0, 2'b00);
      chk("R8 request holds without ack", {30'b0, dreq}, 32'h1);
      cyc(1'b0, 2'd0, '0, '0, 1'b0, 2'b01);
      chk("R8 ack clears ch0", {30'b0, dreq}, 32'h0);
      cyc(1'b0, 2'd0, '0, 16'h0110, 1'b0, '0);
      chk("R6 both channels pending", {30'b0, dreq}, 32'h3);
      cyc(1'b0, 2'd0, '0, 16'h0040, 1'b0, 2'b11);
      chk("R8 trigger with ack keeps ch0", {30'b0, dreq}, 32'h1);
      cyc(1'b0, 2'd0, '0, '0, 1'b0, 2'b01);
      wr(2'd3, 32'h0000_FFFF);
   endtask

   task automatic t_reload();
      logic [31:0] v;
      cyc(1'b0, 2'd0, '0, '0, 1'b1, '0);
      chk("R7 reload ignored when bit30 clear", {30'b0, dreq}, 32'h0);
      wr(2'd1, 32'h4000_0F00);
      cyc(1'b0, 2'd0, '0, '0, 1'b1, '0);
      chk("R7 reload requests ch1", {30'b0, dreq}, 32'h2);
      rd(2'd1, v); chk("R7 R9 ch1 word", v, 32'hC000_0F00);
      cyc(1'b0, 2'd0, '0, '0, 1'b1, 2'b10);
      chk("R8 reload with ack keeps ch1", {30'b0, dreq}, 32'h2);
      cyc(1'b0, 2'd0, '0, '0, 1'b0, 2'b10);
      chk("R8 ack clears ch1", {30'b0, dreq}, 32'h0);
   endtask

   task automatic t_reserved();
      logic [31:0] v;
      wr(2'd2, 32'hFFFF_FFFF);
      rd(2'd2, v); chk("R10 enable reserved bits", v, 32'h0000_FFFF);
      wr(2'd2, 32'h0);
      wr(2'd0, 32'hBFFF_0000);
      rd(2'd0, v); chk("R9 R10 status and reserved writes ignored", v, 32'h0);
      chk("R9 status write makes no request", {30'b0, dreq}, 32'h0);
      cyc(1'b0, 2'd0, '0, 16'h0003, 1'b0, '0);
      wr(2'd3, 32'hFFFF_0000);
      rd(2'd3, v); chk("R10 flag reserved write clears nothing", v, 32'h0000_0003);
      wr(2'd3, 32'h0000_FFFF);
      wr(2'd0, 32'h0000_0001);
      cyc(1'b0, 2'd0, '0, 16'h0001, 1'b0, '0);
      wr(2'd0, 32'h0000_0001);
      rd(2'd0, v); chk("R9 writing zero to status keeps pending", v, 32'h8000_0001);
      cyc(1'b0, 2'd0, '0, '0, 1'b0, 2'b01);
      rd(2'd0, v); chk("R8 R9 pending cleared by ack", v, 32'h0000_0001);
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_flags();
      t_collide();
      t_irq();
      t_dma_evt();
      t_reload();
      t_reserved();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule